// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers event pulses from a two-channel timer and turns them into interrupt requests that software can mask. Each channel reports three kinds of event: a capture or compare match on general register A, the same on register B, and a counter overflow. Every event sets its own sticky status flag. A request line for a source is high only while that source's flag and its enable bit are both set.

Software reaches the block through a small register port. It can read the flags, read and write the enables, and clear flags with a write-zero-to-clear rule. Next to the six request lines, a fixed-priority encoder reports which pending and enabled source has the highest priority. Source index `i = 3*channel + kind` is used everywhere: channel 0 or 1, with kind 0 = A, 1 = B, 2 = overflow. Index 0 has the highest priority and index 5 the lowest.

The register port is a plain control path. It has no back-pressure: each write with `bus_wr` high takes effect at the next clock edge, and reads are combinational from `bus_addr`.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears all flags and all enable bits. While they stay clear, `irq_req` is 0, `irq_valid` is 0 and `irq_idx` is 0.
- R2: An `evt` bit that is high at a clock edge sets the matching flag at that edge. The flag then stays 1 after the pulse ends, until software clears it. Flags read at address 0, with bit i = source i.
- R3: `irq_req[i]` equals flag i AND enable i at all times after reset.
- R4: A write to address 1 loads the enable bits from `bus_wdata[5:0]`, which read back at address 1. Clearing an enable bit masks the request but leaves the flag set. Setting the bit again raises the request again.
- R5: A write to address 0 clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R6: If an event and a clear reach the same flag at the same edge, the flag ends up set.
- R7: `irq_valid` is 1 exactly when any `irq_req` bit is 1. `irq_idx` then gives the lowest set index (ch0-A highest, ch1-overflow lowest). It is 0 when none is set.
- R8: Reads of addresses 2 and 3 return 0, and writes to them change no flag and no enable bit. Read data bits above bit 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 6 | Single-cycle event pulses, bit 3*ch+kind |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 flags, 1 enables) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_req | output | 6 | Per-source gated request |
| irq_valid | output | 1 | Some request is pending |
| irq_idx | output | 3 | Index of the highest-priority pending request |

## Verification
The bench sweeps every flag pattern against every enable pattern. This catches an encoder that favours the wrong end of the vector, which would report the lowest-priority source when several are pending. It also catches a gate that lets a disabled flag request, or that loses the flag when its enable drops. A second sweep crosses every flag pattern with every clear mask and adds an event on the same edge. A design that gives the clear precedence would lose an event that lands on the clear cycle, and one with an inverted clear sense would wipe flags that were written with 1. Writes to the unused addresses, and a reset taken in mid-operation, show up as corrupted or leftover state in the read-back.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned KIND_A   = 0;
  localparam int unsigned KIND_B   = 1;
  localparam int unsigned KIND_OVF = 2;
  localparam logic [1:0] ADDR_FLAGS  = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;

  function automatic int unsigned src_index(input int unsigned ch, input int unsigned kind,
                                            input int unsigned per_ch);
    return ch * per_ch + kind;
  endfunction
endpackage

// File: rtl/tic_flag_cell.sv
module tic_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !flag_o);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst) (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/tic_flag_bank.sv
module tic_flag_bank #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] keep_i,
  output logic [NUM_SRC-1:0] flags_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    tic_flag_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt_i[i]),
      .clr_i (wr_i & ~keep_i[i]),
      .flag_o(flags_o[i])
    );
  end
endmodule

// File: rtl/tic_enable_reg.sv
module tic_enable_reg #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)       en_o <= '0;
    else if (wr_i) en_o <= wdata_i;
  end

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (rst) wr_i |=> en_o == $past(wdata_i));
  // R8
  en_keep_chk: assert property (@(posedge clk) disable iff (rst) !wr_i |=> $stable(en_o));
endmodule

// File: rtl/tic_prio_enc.sv
module tic_prio_enc #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned SRC_PER_CH = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH*SRC_PER_CH-1:0] evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH*SRC_PER_CH-1:0] irq_req,
  output logic              irq_valid,
  output logic [$clog2(NUM_CH*SRC_PER_CH)-1:0] irq_idx
);
  import tic_pkg::*;

  localparam int unsigned NUM_SRC = NUM_CH * SRC_PER_CH;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] enables;
  logic               wr_flags;
  logic               wr_enable;

  assign wr_flags  = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAGS));
  assign wr_enable = bus_wr && (bus_addr == ADDR_W'(ADDR_ENABLE));

  tic_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt),
    .wr_i   (wr_flags),
    .keep_i (bus_wdata[NUM_SRC-1:0]),
    .flags_o(flags)
  );

  tic_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_enable),
    .wdata_i(bus_wdata[NUM_SRC-1:0]),
    .en_o   (enables)
  );

  assign irq_req = flags & enables;

  tic_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i  (irq_req),
    .valid_o(irq_valid),
    .idx_o  (irq_idx)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_FLAGS))       bus_rdata[NUM_SRC-1:0] = flags;
    else if (bus_addr == ADDR_W'(ADDR_ENABLE)) bus_rdata[NUM_SRC-1:0] = enables;
  end

  // R7
  prio_valid_chk: assert property (@(posedge clk) disable iff (rst) irq_valid == (irq_req != '0));
  // R7
  prio_hit_chk: assert property (@(posedge clk) disable iff (rst) irq_valid |-> irq_req[irq_idx]);
  // R7
  prio_top_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((irq_req & ((NUM_SRC'(1) << irq_idx) - NUM_SRC'(1))) == '0));
  // R3
  req_mask_chk: assert property (@(posedge clk) disable iff (rst) $fell(enables[0]) |-> !irq_req[0]);
endmodule

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] irq_req;
  logic       irq_valid;
  logic [2:0] irq_idx;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic load_flags(input logic [5:0] p);
    wr(2'd0, 8'h00);
    evt = p;
    tick();
    evt = '0;
  endtask

  task automatic check_prio(input string req, input logic [5:0] r);
    int exp_idx = 0;
    for (int i = 5; i >= 0; i--) if (r[i]) exp_idx = i;
    chk(req, int'(irq_valid), int'(r != 0));
    chk(req, int'(irq_idx), exp_idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    @(negedge clk); tick(); rst = 1'b0;
    // R1 reset state
    rd(2'd0, d); chk("R1", d, 0);
    rd(2'd1, d); chk("R1", d, 0);
    chk("R1", int'(irq_req), 0);
    chk("R1", int'(irq_valid), 0);
    chk("R1", int'(irq_idx), 0);

    // R2 R3 R4 R7: every flag pattern against every enable pattern
    for (int f = 0; f < 64; f++) begin
      for (int e = 0; e < 64; e++) begin
        load_flags(6'(f));
        wr(2'd1, 8'(e));
        tick();
        rd(2'd0, d); chk("R2", d, f);
        rd(2'd1, d); chk("R4", d, e);
        chk("R3", int'(irq_req), f & e);
        check_prio("R7", 6'(f & e));
      end
    end

    // R4 re-enable after masking keeps the flag
    load_flags(6'h24);
    wr(2'd1, 8'h00);
    chk("R4", int'(irq_req), 0);
    rd(2'd0, d); chk("R4", d, 'h24);
    wr(2'd1, 8'h3F);
    chk("R4", int'(irq_req), 'h24);

    // R5 R6: clear mask crossed with flags, with an event on the clear edge
    for (int f = 0; f < 64; f++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] ev;
        ev = 6'((f * 5 + m * 3) & 63) & ~6'(m);
        load_flags(6'(f));
        evt = ev;
        wr(2'd0, 8'(m));
        evt = '0;
        rd(2'd0, d);
        if (ev == 0) chk("R5", d, f & m);
        else         chk("R6", d, (f & m) | int'(ev));
      end
    end

    // R8 unused addresses
    load_flags(6'h15);
    wr(2'd1, 8'h2A);
    for (int a = 2; a < 4; a++) begin
      for (int v = 0; v < 256; v += 17) begin
        wr(2'(a), 8'(v));
        rd(2'(a), d); chk("R8", d, 0);
      end
    end
    rd(2'd0, d); chk("R8", d, 'h15);
    rd(2'd1, d); chk("R8", d, 'h2A);

    // R1 reset in mid-operation
    rst = 1'b1; tick(); rst = 1'b0;
    rd(2'd0, d); chk("R1", d, 0);
    rd(2'd1, d); chk("R1", d, 0);
    chk("R1", int'(irq_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule